// File: doc/BRIEF.md
# Speculative Stream Iteration Map

This block keeps, for every active stream, the number of the element that the next dispatched instruction refers to. A group of up to `SLOTS` instructions dispatches each cycle, in program order from slot 0 upward. A slot is either a step, which advances its stream by one element, or a use, which reads the stream's current element. Each valid slot on a live stream leaves the block tagged with an iteration number. Downstream logic uses that tag to pick the matching entry of the stream's data buffer.

When control misspeculation squashes dispatched steps, each squash lane names one stream, and that stream's counter goes back by one per lane. Nothing else changes. Already fetched elements stay where they are, because the tags of the surviving instructions still index them correctly. A command port opens a stream with its counter at zero, or closes it.

Tags and error flags are combinational from the registered map and the current dispatch group. All counter updates take effect at the next rising edge.

Top module: `stream_iter_map`

## Requirements
- R1: After reset every stream is closed. Every valid slot reports error 1 and tag 0, and invalid slots always report error 0 and tag 0.
- R2: A configure command (`cmd_valid`=1, `cmd_op`=0) opens the named stream. From the next cycle the stream is open and its counter is 0.
- R3: An end command (`cmd_op`=1) closes the named stream. A slot naming a closed stream reports error 1 and tag 0. Steps and squashes naming a closed stream are ignored, so after a later configure the stream still starts at 0.
- R4: A step slot (`slot_step`=1) on an open stream is tagged with the value its stream's counter holds before that step. The counter grows by the number of such steps in the group.
- R5: A use slot (`slot_step`=0) is tagged with the stream's registered counter plus the number of steps to the same stream in lower-numbered slots of the same group. A use placed ahead of a step therefore sees the pre-increment value.
- R6: Several steps to one stream in one group receive consecutive tags, in slot order.
- R7: Each valid squash lane subtracts one from its open stream's counter. Lanes naming the same stream accumulate, and the net change combines with that cycle's steps.
- R8: Steps, uses and squashes on one stream never alter another stream's counter.
- R9: A command in the same cycle as steps or squashes to the same stream overrides them for the next state. Slots in that cycle still see the state from before the command.
- R10: Counters are `ITER_W` bits wide and wrap modulo 2^ITER_W in both directions.
- R11: With no command, no valid slot and no valid squash lane, no counter and no open/closed state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 1 | 0 = configure (open, counter 0), 1 = end (close) |
| cmd_sid | input | SID_W | Stream named by the command |
| slot_valid | input | SLOTS | Per dispatch slot: instruction present |
| slot_step | input | SLOTS | Per slot: 1 = step, 0 = use |
| slot_sid | input | SLOTS x SID_W | Per slot: stream id |
| slot_iter | output | SLOTS x ITER_W | Per slot: iteration tag |
| slot_err | output | SLOTS | Per slot: stream named is closed |
| squash_valid | input | SQUASH | Per lane: one misspeculated step undone |
| squash_sid | input | SQUASH x SID_W | Per lane: stream of the squashed step |

## Verification
The properties assume three things about the inputs. Stream ids are always below `NSTREAM`. Inputs change only away from the rising edge. The dispatch width is far below 2^ITER_W, so a step always moves its counter to a value different from its own tag. The bench drives every input on the falling edge and draws stream ids only from the valid range. Its squash lanes may name any stream, including one with a zero counter, so wrapping below zero is covered rather than excluded. Directed groups place uses ahead of, between and behind steps to the same stream, and let commands collide with steps and squashes.

// File: rtl/stream_map_pkg.sv
package stream_map_pkg;

    localparam int unsigned DEF_NSTREAM = 8;
    localparam int unsigned DEF_ITER_W  = 12;
    localparam int unsigned DEF_SLOTS   = 4;
    localparam int unsigned DEF_SQUASH  = 4;

    typedef enum logic {
        SLOT_USE  = 1'b0,
        SLOT_STEP = 1'b1
    } slot_kind_e;

    typedef enum logic {
        CMD_CONFIG = 1'b0,
        CMD_END    = 1'b1
    } cmd_op_e;

endpackage

// File: rtl/stream_step_rank.sv
// For each dispatch slot, counts the older steps (lower slot index) that
// name the same stream. Slot 0 is the oldest instruction of the group.
module stream_step_rank #(
    parameter int unsigned SLOTS  = 4,
    parameter int unsigned SID_W  = 3,
    parameter int unsigned RANK_W = 3
) (
    input  logic [SLOTS-1:0]             slot_valid,
    input  logic [SLOTS-1:0]             slot_step,
    input  logic [SLOTS-1:0][SID_W-1:0]  slot_sid,
    output logic [SLOTS-1:0][RANK_W-1:0] rank
);

    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
        logic [RANK_W-1:0] acc;
        always_comb begin
            acc = '0;
            for (int i = 0; i < j; i++) begin
                if (slot_valid[i] && slot_step[i] && (slot_sid[i] == slot_sid[j])) begin
                    acc = acc + RANK_W'(1);
                end
            end
        end
        assign rank[j] = acc;
    end

endmodule

// File: rtl/stream_net_delta.sv
// Per stream: steps dispatched minus squashes, as a modular ITER_W value.
module stream_net_delta #(
    parameter int unsigned NSTREAM = 8,
    parameter int unsigned SID_W   = 3,
    parameter int unsigned SLOTS   = 4,
    parameter int unsigned SQUASH  = 4,
    parameter int unsigned ITER_W  = 12
) (
    input  logic [SLOTS-1:0]              slot_valid,
    input  logic [SLOTS-1:0]              slot_step,
    input  logic [SLOTS-1:0][SID_W-1:0]   slot_sid,
    input  logic [SQUASH-1:0]             squash_valid,
    input  logic [SQUASH-1:0][SID_W-1:0]  squash_sid,
    output logic [NSTREAM-1:0][ITER_W-1:0] delta
);

    localparam int unsigned UP_W = $clog2(SLOTS + 1);
    localparam int unsigned DN_W = $clog2(SQUASH + 1);

    for (genvar s = 0; s < NSTREAM; s++) begin : g_stream
        logic [UP_W-1:0] up;
        logic [DN_W-1:0] dn;
        always_comb begin
            up = '0;
            for (int i = 0; i < SLOTS; i++) begin
                if (slot_valid[i] && slot_step[i] && (slot_sid[i] == SID_W'(s))) begin
                    up = up + UP_W'(1);
                end
            end
            dn = '0;
            for (int k = 0; k < SQUASH; k++) begin
                if (squash_valid[k] && (squash_sid[k] == SID_W'(s))) begin
                    dn = dn + DN_W'(1);
                end
            end
        end
        assign delta[s] = ITER_W'(up) - ITER_W'(dn);
    end

endmodule

// File: rtl/stream_iter_map.sv
module stream_iter_map
    import stream_map_pkg::*;
#(
    parameter  int unsigned NSTREAM = DEF_NSTREAM,
    parameter  int unsigned ITER_W  = DEF_ITER_W,
    parameter  int unsigned SLOTS   = DEF_SLOTS,
    parameter  int unsigned SQUASH  = DEF_SQUASH,
    localparam int unsigned SID_W   = (NSTREAM > 1) ? $clog2(NSTREAM) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cmd_valid,
    input  logic                           cmd_op,
    input  logic [SID_W-1:0]               cmd_sid,
    input  logic [SLOTS-1:0]               slot_valid,
    input  logic [SLOTS-1:0]               slot_step,
    input  logic [SLOTS-1:0][SID_W-1:0]    slot_sid,
    output logic [SLOTS-1:0][ITER_W-1:0]   slot_iter,
    output logic [SLOTS-1:0]               slot_err,
    input  logic [SQUASH-1:0]              squash_valid,
    input  logic [SQUASH-1:0][SID_W-1:0]   squash_sid
);

    localparam int unsigned RANK_W = $clog2(SLOTS + 1);

    typedef struct packed {
        logic [NSTREAM-1:0]             live;
        logic [NSTREAM-1:0][ITER_W-1:0] iter;
    } map_t;

    map_t st_d, st_q;

    logic [SLOTS-1:0][RANK_W-1:0]   rank;
    logic [NSTREAM-1:0][ITER_W-1:0] net_delta;

    stream_step_rank #(
        .SLOTS (SLOTS),
        .SID_W (SID_W),
        .RANK_W(RANK_W)
    ) u_rank (
        .slot_valid(slot_valid),
        .slot_step (slot_step),
        .slot_sid  (slot_sid),
        .rank      (rank)
    );

    stream_net_delta #(
        .NSTREAM(NSTREAM),
        .SID_W  (SID_W),
        .SLOTS  (SLOTS),
        .SQUASH (SQUASH),
        .ITER_W (ITER_W)
    ) u_delta (
        .slot_valid  (slot_valid),
        .slot_step   (slot_step),
        .slot_sid    (slot_sid),
        .squash_valid(squash_valid),
        .squash_sid  (squash_sid),
        .delta       (net_delta)
    );

    function automatic logic sid_in_range(logic [SID_W-1:0] sid);
        return int'(sid) < int'(NSTREAM);
    endfunction

    always_comb begin
        st_d = st_q;

        // Dispatched steps and squashed steps only move open streams.
        for (int s = 0; s < NSTREAM; s++) begin
            if (st_q.live[s]) begin
                st_d.iter[s] = st_q.iter[s] + net_delta[s];
            end
        end

        // A command takes precedence over this cycle's traffic on its stream.
        if (cmd_valid && sid_in_range(cmd_sid)) begin
            if (cmd_op == CMD_END) begin
                st_d.live[cmd_sid] = 1'b0;
            end else begin
                st_d.live[cmd_sid] = 1'b1;
                st_d.iter[cmd_sid] = '0;
            end
        end

        // Tags come from the registered map plus older steps in the group.
        for (int j = 0; j < SLOTS; j++) begin
            slot_err[j]  = 1'b0;
            slot_iter[j] = '0;
            if (slot_valid[j]) begin
                if (sid_in_range(slot_sid[j]) && st_q.live[slot_sid[j]]) begin
                    slot_iter[j] = st_q.iter[slot_sid[j]] + ITER_W'(rank[j]);
                end else begin
                    slot_err[j] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/stream_iter_map_chk.sv
module stream_iter_map_chk
    import stream_map_pkg::*;
#(
    parameter  int unsigned NSTREAM = DEF_NSTREAM,
    parameter  int unsigned ITER_W  = DEF_ITER_W,
    parameter  int unsigned SLOTS   = DEF_SLOTS,
    parameter  int unsigned SQUASH  = DEF_SQUASH,
    localparam int unsigned SID_W   = (NSTREAM > 1) ? $clog2(NSTREAM) : 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cmd_valid,
    input logic                           cmd_op,
    input logic [SID_W-1:0]               cmd_sid,
    input logic [SLOTS-1:0]               slot_valid,
    input logic [SLOTS-1:0]               slot_step,
    input logic [SLOTS-1:0][SID_W-1:0]    slot_sid,
    input logic [SLOTS-1:0][ITER_W-1:0]   slot_iter,
    input logic [SLOTS-1:0]               slot_err,
    input logic [SQUASH-1:0]              squash_valid,
    input logic [SQUASH-1:0][SID_W-1:0]   squash_sid,
    input logic [NSTREAM-1:0]             live_q,
    input logic [NSTREAM-1:0][ITER_W-1:0] iter_q
);

    p_cfg_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_CONFIG)
        |=> (live_q[$past(cmd_sid)] && iter_q[$past(cmd_sid)] == '0));

    p_end_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_END) |=> !live_q[$past(cmd_sid)]);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && slot_valid == '0 && squash_valid == '0)
        |=> ($stable(iter_q) && $stable(live_q)));

    p_squash_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && slot_valid == '0 && squash_valid == SQUASH'(1)
         && live_q[squash_sid[0]])
        |=> iter_q[$past(squash_sid[0])] == ITER_W'($past(iter_q[squash_sid[0]]) - ITER_W'(1)));

    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
        p_err_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
            slot_err[j] |-> slot_valid[j]);

        p_step_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_valid[j] && slot_step[j] && !slot_err[j] && squash_valid == '0
             && !(cmd_valid && cmd_sid == slot_sid[j]))
            |=> iter_q[$past(slot_sid[j])] != $past(slot_iter[j]));
    end

    for (genvar j = 0; j + 1 < SLOTS; j++) begin : g_pair
        p_consecutive_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_valid[j] && slot_step[j] && !slot_err[j]
             && slot_valid[j+1] && slot_step[j+1] && slot_sid[j] == slot_sid[j+1])
            |-> slot_iter[j+1] == ITER_W'(slot_iter[j] + ITER_W'(1)));
    end

endmodule

bind stream_iter_map stream_iter_map_chk #(
    .NSTREAM(NSTREAM),
    .ITER_W (ITER_W),
    .SLOTS  (SLOTS),
    .SQUASH (SQUASH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_sid     (cmd_sid),
    .slot_valid  (slot_valid),
    .slot_step   (slot_step),
    .slot_sid    (slot_sid),
    .slot_iter   (slot_iter),
    .slot_err    (slot_err),
    .squash_valid(squash_valid),
    .squash_sid  (squash_sid),
    .live_q      (st_q.live),
    .iter_q      (st_q.iter)
);

// File: tb/stream_iter_map_test.sv
`timescale 1ns/1ps
module stream_iter_map_test;

    localparam int NS   = 8;
    localparam int IW   = 12;
    localparam int SL   = 4;
    localparam int SQ   = 4;
    localparam int SW   = 3;
    localparam int MASK = (1 << IW) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cmd_valid, cmd_op;
    logic [SW-1:0]        cmd_sid;
    logic [SL-1:0]        slot_valid, slot_step;
    logic [SL-1:0][SW-1:0] slot_sid;
    logic [SL-1:0][IW-1:0] slot_iter;
    logic [SL-1:0]        slot_err;
    logic [SQ-1:0]        squash_valid;
    logic [SQ-1:0][SW-1:0] squash_sid;

    int cnt [NS];
    bit live[NS];
    int vectors = 0;
    int errors  = 0;

    always #2.5 clk = ~clk;

    stream_iter_map #(.NSTREAM(NS), .ITER_W(IW), .SLOTS(SL), .SQUASH(SQ)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sid(cmd_sid),
        .slot_valid(slot_valid), .slot_step(slot_step), .slot_sid(slot_sid),
        .slot_iter(slot_iter), .slot_err(slot_err),
        .squash_valid(squash_valid), .squash_sid(squash_sid)
    );

    task automatic clr();
        cmd_valid = 1'b0; cmd_op = 1'b0; cmd_sid = '0;
        slot_valid = '0; slot_step = '0; slot_sid = '0;
        squash_valid = '0; squash_sid = '0;
    endtask

    task automatic slot(int j, bit st, int sid);
        slot_valid[j] = 1'b1; slot_step[j] = st; slot_sid[j] = SW'(sid);
    endtask

    task automatic sq(int k, int sid);
        squash_valid[k] = 1'b1; squash_sid[k] = SW'(sid);
    endtask

    task automatic cmd(bit op, int sid);
        cmd_valid = 1'b1; cmd_op = op; cmd_sid = SW'(sid);
    endtask

    // Compares the current group against the model, then advances the model.
    task automatic cycle(string tag);
        int tmp[NS];
        #1;
        for (int s = 0; s < NS; s++) tmp[s] = cnt[s];
        for (int j = 0; j < SL; j++) begin
            int sid;
            bit eerr;
            int eit;
            sid  = int'(slot_sid[j]);
            eerr = 1'b0;
            eit  = 0;
            if (slot_valid[j]) begin
                if (live[sid]) begin
                    eit = tmp[sid];
                    if (slot_step[j]) tmp[sid] = (tmp[sid] + 1) & MASK;
                end else begin
                    eerr = 1'b1;
                end
            end
            vectors++;
            if (slot_err[j] !== eerr || slot_iter[j] !== IW'(eit)) begin
                errors++;
                $display("FAIL %s slot %0d: err=%0b iter=%0d expected err=%0b iter=%0d",
                         tag, j, slot_err[j], slot_iter[j], eerr, eit);
            end
        end
        for (int k = 0; k < SQ; k++) begin
            if (squash_valid[k] && live[int'(squash_sid[k])])
                tmp[int'(squash_sid[k])] = (tmp[int'(squash_sid[k])] - 1) & MASK;
        end
        for (int s = 0; s < NS; s++) if (live[s]) cnt[s] = tmp[s];
        if (cmd_valid) begin
            if (cmd_op) live[int'(cmd_sid)] = 1'b0;
            else begin live[int'(cmd_sid)] = 1'b1; cnt[int'(cmd_sid)] = 0; end
        end
        @(negedge clk);
        clr();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++) begin cnt[s] = 0; live[s] = 1'b0; end
        clr();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything closed after reset
        for (int j = 0; j < SL; j++) slot(j, j[0], j);
        cycle("R1");
        cycle("R1");

        // R2: open streams 0, 1, 2 one per cycle
        cmd(1'b0, 0); cycle("R2");
        cmd(1'b0, 1); slot(0, 1'b0, 0); cycle("R2");
        cmd(1'b0, 2); slot(0, 1'b0, 1); cycle("R2");

        // R5 / R4: use, step, use, step on stream 0 -> tags 0,0,1,1
        slot(0, 1'b0, 0); slot(1, 1'b1, 0); slot(2, 1'b0, 0); slot(3, 1'b1, 0);
        cycle("R5");
        slot(0, 1'b0, 0); cycle("R4");

        // R6: four steps on stream 1 -> 0,1,2,3
        for (int j = 0; j < SL; j++) slot(j, 1'b1, 1);
        cycle("R6");
        slot(0, 1'b0, 1); slot(1, 1'b0, 2); cycle("R6");

        // R7: two squashes on 1, one on 0, with a step on 0 in the same cycle
        sq(0, 1); sq(2, 1); sq(3, 0); slot(0, 1'b1, 0);
        cycle("R7");
        slot(0, 1'b0, 1); slot(1, 1'b0, 0); cycle("R7");

        // R8: stepping stream 1 leaves stream 2 alone
        slot(0, 1'b1, 1); slot(1, 1'b0, 2); slot(2, 1'b1, 1); slot(3, 1'b0, 2);
        cycle("R8");
        slot(0, 1'b0, 2); slot(1, 1'b0, 1); cycle("R8");

        // R9: configure 1 while stepping it, end 2 while stepping it
        cmd(1'b0, 1); slot(0, 1'b1, 1); slot(1, 1'b0, 1); sq(0, 1);
        cycle("R9");
        slot(0, 1'b0, 1); cmd(1'b1, 2); slot(1, 1'b1, 2); slot(2, 1'b0, 2);
        cycle("R9");

        // R3: closed stream errors; its steps and squashes are ignored
        slot(0, 1'b1, 2); slot(1, 1'b0, 2); slot(2, 1'b0, 1); sq(1, 2);
        cycle("R3");
        cmd(1'b0, 2); cycle("R3");
        slot(0, 1'b0, 2); slot(1, 1'b1, 5); cycle("R3");

        // R10: wrap upward on stream 7, then below zero
        cmd(1'b0, 7); cycle("R10");
        for (int n = 0; n < (1 << IW) / SL; n++) begin
            for (int j = 0; j < SL; j++) slot(j, 1'b1, 7);
            cycle("R10");
        end
        slot(0, 1'b0, 7); sq(0, 7); cycle("R10");
        slot(0, 1'b0, 7); slot(1, 1'b1, 7); slot(2, 1'b0, 7); cycle("R10");

        // R11: idle cycles change nothing
        repeat (4) cycle("R11");
        for (int j = 0; j < SL; j++) slot(j, 1'b0, j);
        cycle("R11");

        // Mixed traffic across all features
        for (int n = 0; n < 2000; n++) begin
            if ($urandom % 16 == 0) cmd(1'($urandom % 4 == 0), int'($urandom % NS));
            for (int j = 0; j < SL; j++)
                if ($urandom % 10 < 7) slot(j, 1'($urandom % 2), int'($urandom % 4));
            for (int k = 0; k < SQ; k++)
                if ($urandom % 4 == 0) sq(k, int'($urandom % 4));
            cycle("R8 mixed");
        end

        summary();
        $finish;
    end

endmodule